// File: doc/BRIEF.md
# Illegal Opcode Trap Detector

This block watches the opcode bytes that a small CPU fetches. The CPU has four opcode pages. An optional prefix byte in front of an opcode picks pages 2, 3 or 4. For every fetched byte, the block decides whether the byte is a prefix or an opcode. For an opcode, it works out the page and looks the (page, opcode) pair up in a constant legality bitmap. The bitmap is set as a parameter.

When the pair is undefined, the block issues a one-cycle trap request toward the illegal-opcode vector. Alongside the request it presents the return address that the core must stack. That address is the address of the first byte of the offending instruction, which for a prefixed opcode is the prefix byte. A mode input marks the special test or bootstrap modes. In those modes the page-1 opcode $00 is accepted; in normal modes it traps. A flush input drops any pending prefix, so that a prefix seen before a branch or an interrupt does not attach to a byte fetched afterwards.

Top module: `illegal_op_trap`

## Requirements
- R1: During and right after a synchronous reset, `trap_req` is 0, `trap_addr` is 0 and `trap_page` is 0.
- R2: An opcode fetch of $18, $1A or $CD with no prefix pending is a prefix byte. It never raises a trap, and it makes the next fetched byte an opcode on page 2, 3 or 4 respectively. `trap_page` reports pages 1 to 4 as codes 0 to 3.
- R3: On page 1, the byte traps when its high nibble is 4 to 7 and its low nibble is 1, 2, 5 or B. $87 and $C7 also trap. Every other page-1 byte is legal. A page-1 trap reports the opcode's own address and page code 0.
- R4: On page 2, these bytes are legal: any byte with high nibble 6, A or E, plus $08, $09, $1C to $1F, $30, $35, $38, $3A, $3C, $8C, $8F, $9C, $CE, $DE, $DF, $FE and $FF. Every other byte traps, and `trap_addr` is the address of the prefix byte.
- R5: On page 3, only $83, $93, $A3, $B3, $AC, $EE and $EF are legal. Others trap with the prefix address.
- R6: On page 4, only $A3, $AC, $EE and $EF are legal. Others trap with the prefix address.
- R7: The page-1 opcode $00 is legal while `special_mode` is 1 and traps while it is 0. On pages 2 to 4, $00 traps in both modes.
- R8: `trap_req` rises in the cycle after the edge that samples an illegal opcode, and it lasts one cycle per illegal opcode. Illegal opcodes fetched in consecutive cycles give consecutive pulses. A cycle with no fetch or with a legal fetch yields no pulse.
- R9: `flush` cancels a pending prefix. If `flush` arrives together with the byte that follows a prefix, that byte is decoded on page 1 at its own address. If `flush` arrives with a prefix byte, that prefix becomes the new pending prefix.
- R10: `trap_addr` and `trap_page` keep their values until the next trap.
- R11: While `fetch_valid` is 0, `fetch_byte` is ignored and a pending prefix is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An opcode-stream byte is presented this cycle |
| fetch_byte | input | 8 | Fetched byte |
| fetch_addr | input | ADDR_W | Address of the fetched byte |
| special_mode | input | 1 | 1 in special test or bootstrap modes |
| flush | input | 1 | Drop any pending prefix |
| trap_req | output | 1 | One-cycle illegal-opcode trap request |
| trap_addr | output | ADDR_W | Return address to stack (first byte of offender) |
| trap_page | output | 2 | Page code of the offending opcode (0 to 3) |

## Verification
A flush can land in the same cycle as the byte that completes a prefixed opcode. In that cycle the byte must lose its page and its prefix address. The bench provokes this by sending $18 and then $61 with `flush` high. $61 is legal on page 2 but illegal on page 1, so the expected result is a trap at the $61 address with page code 0. The bench also sends a flush together with a new prefix byte and expects that prefix to stay in force, so the following $61 passes without a trap.

// File: rtl/iot_pkg.sv
package iot_pkg;

  localparam int OP_W      = 8;
  localparam int NUM_PAGES = 4;
  localparam int PAGE_W    = $clog2(NUM_PAGES);
  localparam int NUM_PFX   = NUM_PAGES - 1;
  localparam int MAP_BITS  = NUM_PAGES * (1 << OP_W);

  typedef enum logic [PAGE_W-1:0] {PG1 = 2'd0, PG2 = 2'd1, PG3 = 2'd2, PG4 = 2'd3} page_t;

  // Builds the default legality bitmap; bit index = {page, opcode}.
  function automatic logic [MAP_BITS-1:0] iot_default_map();
    logic [MAP_BITS-1:0] m;
    logic [7:0] b;
    logic [3:0] hi;
    logic [3:0] lo;
    m = '0;
    for (int op = 0; op < 256; op++) begin
      b  = 8'(op);
      hi = b[7:4];
      lo = b[3:0];
      m[10'(op)] = !(((hi >= 4'h4) && (hi <= 4'h7) &&
                      (lo == 4'h1 || lo == 4'h2 || lo == 4'h5 || lo == 4'hB)) ||
                     b == 8'h87 || b == 8'hC7);
      m[10'(256 + op)] = (hi == 4'h6) || (hi == 4'hA) || (hi == 4'hE) ||
                         (b inside {8'h08, 8'h09, 8'h30, 8'h35, 8'h38, 8'h3A, 8'h3C,
                                    8'h8C, 8'h8F, 8'h9C, 8'hCE, 8'hDE, 8'hDF,
                                    8'hFE, 8'hFF}) ||
                         ((b >= 8'h1C) && (b <= 8'h1F));
      m[10'(512 + op)] = b inside {8'h83, 8'h93, 8'hA3, 8'hB3, 8'hAC, 8'hEE, 8'hEF};
      m[10'(768 + op)] = b inside {8'hA3, 8'hAC, 8'hEE, 8'hEF};
    end
    return m;
  endfunction

endpackage

// File: rtl/iot_page_tracker.sv
module iot_page_tracker
  import iot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [NUM_PFX*OP_W-1:0] PREFIX_BYTES = {8'hCD, 8'h1A, 8'h18}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [OP_W-1:0]   fetch_byte,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              flush,
  output logic              is_opcode,
  output page_t             op_page,
  output logic [ADDR_W-1:0] start_addr
);

  logic [NUM_PFX-1:0] hit;
  page_t              hit_page;
  logic               pend_q;
  page_t              pend_page_q;
  logic [ADDR_W-1:0]  pend_addr_q;
  logic               pend_eff;
  logic               is_pfx;

  for (genvar i = 0; i < NUM_PFX; i++) begin : g_pfx
    assign hit[i] = (fetch_byte == PREFIX_BYTES[i*OP_W +: OP_W]);
  end

  always_comb begin
    hit_page = PG1;
    for (int i = 0; i < NUM_PFX; i++) begin
      if (hit[i]) hit_page = page_t'(PAGE_W'(i + 1));
    end
  end

  // A flush in this cycle discards the pending prefix before decode.
  assign pend_eff   = pend_q && !flush;
  assign is_pfx     = fetch_valid && !pend_eff && (|hit);
  assign is_opcode  = fetch_valid && !is_pfx;
  assign op_page    = pend_eff ? pend_page_q : PG1;
  assign start_addr = pend_eff ? pend_addr_q : fetch_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_page_q <= PG1;
      pend_addr_q <= '0;
    end else if (fetch_valid) begin
      pend_q <= is_pfx;
      if (is_pfx) begin
        pend_page_q <= hit_page;
        pend_addr_q <= fetch_addr;
      end
    end else if (flush) begin
      pend_q <= 1'b0;
    end
  end

  AST_FLUSH_DROPS_PREFIX: assert property (@(posedge clk) disable iff (rst)
    (flush && !fetch_valid) |=> !pend_q); // R9

  AST_IDLE_KEEPS_PREFIX: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && !flush) |=> $stable(pend_q) && $stable(pend_addr_q)); // R11

endmodule

// File: rtl/iot_legality.sv
module iot_legality
  import iot_pkg::*;
#(
  parameter logic [MAP_BITS-1:0] LEGAL_MAP = iot_default_map()
) (
  input  page_t           page,
  input  logic [OP_W-1:0] opcode,
  input  logic            special_mode,
  output logic            legal
);

  logic [PAGE_W+OP_W-1:0] idx;
  logic                   map_bit;
  logic                   is_test_op;

  assign idx        = {page, opcode};
  assign map_bit    = LEGAL_MAP[idx];
  assign is_test_op = (page == PG1) && (opcode == '0);
  // The page-1 zero opcode is governed by the mode input, not the map.
  assign legal      = is_test_op ? special_mode : map_bit;

endmodule

// File: rtl/iot_trap_reg.sv
module iot_trap_reg
  import iot_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [ADDR_W-1:0] start_addr,
  input  page_t             page,
  output logic              trap_req,
  output logic [ADDR_W-1:0] trap_addr,
  output logic [PAGE_W-1:0] trap_page
);

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req  <= 1'b0;
      trap_addr <= '0;
      trap_page <= '0;
    end else begin
      trap_req <= fire;
      if (fire) begin
        trap_addr <= start_addr;
        trap_page <= page;
      end
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(trap_addr) && $stable(trap_page)); // R10

endmodule

// File: rtl/illegal_op_trap.sv
module illegal_op_trap
  import iot_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [NUM_PFX*OP_W-1:0] PREFIX_BYTES = {8'hCD, 8'h1A, 8'h18},
  parameter logic [MAP_BITS-1:0] LEGAL_MAP = iot_default_map()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic [7:0]        fetch_byte,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              special_mode,
  input  logic              flush,
  output logic              trap_req,
  output logic [ADDR_W-1:0] trap_addr,
  output logic [1:0]        trap_page
);

  logic              is_opcode;
  page_t             op_page;
  logic [ADDR_W-1:0] start_addr;
  logic              legal;
  logic              fire;

  iot_page_tracker #(.ADDR_W(ADDR_W), .PREFIX_BYTES(PREFIX_BYTES)) u_track (
    .clk        (clk),
    .rst        (rst),
    .fetch_valid(fetch_valid),
    .fetch_byte (fetch_byte),
    .fetch_addr (fetch_addr),
    .flush      (flush),
    .is_opcode  (is_opcode),
    .op_page    (op_page),
    .start_addr (start_addr)
  );

  iot_legality #(.LEGAL_MAP(LEGAL_MAP)) u_legal (
    .page        (op_page),
    .opcode      (fetch_byte),
    .special_mode(special_mode),
    .legal       (legal)
  );

  assign fire = is_opcode && !legal;

  iot_trap_reg #(.ADDR_W(ADDR_W)) u_trap (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .start_addr(start_addr),
    .page      (op_page),
    .trap_req  (trap_req),
    .trap_addr (trap_addr),
    .trap_page (trap_page)
  );

  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !is_opcode) |=> !trap_req); // R2

  AST_NO_FETCH_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !trap_req); // R8

  AST_ZERO_SPECIAL: assert property (@(posedge clk) disable iff (rst)
    (is_opcode && op_page == PG1 && fetch_byte == 8'h00 && special_mode) |=> !trap_req); // R7

  AST_ZERO_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (is_opcode && op_page == PG1 && fetch_byte == 8'h00 && !special_mode)
      |=> trap_req && trap_addr == $past(fetch_addr)); // R7

  AST_PREFIX_ADDR: assert property (@(posedge clk) disable iff (rst)
    (fire && op_page != PG1) |=> trap_req && trap_addr != $past(fetch_addr) - ADDR_W'(1) ||
                                 trap_addr == $past(start_addr)); // R4

endmodule

// File: tb/tb_illegal_op_trap.sv
module tb_illegal_op_trap;

  logic        clk = 1'b0;
  logic        rst;
  logic        fetch_valid;
  logic [7:0]  fetch_byte;
  logic [15:0] fetch_addr;
  logic        special_mode;
  logic        flush;
  logic        trap_req;
  logic [15:0] trap_addr;
  logic [1:0]  trap_page;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #10 clk = ~clk;

  illegal_op_trap dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .fetch_addr(fetch_addr), .special_mode(special_mode), .flush(flush),
    .trap_req(trap_req), .trap_addr(trap_addr), .trap_page(trap_page)
  );

  // Reference legality, written from R3..R7. pg: 0..3 = pages 1..4.
  function automatic bit ref_legal(input int pg, input logic [7:0] b, input bit sp);
    logic [3:0] hi, lo;
    hi = b[7:4];
    lo = b[3:0];
    case (pg)
      0: begin
        if (b == 8'h00) return sp;
        if (b == 8'h87 || b == 8'hC7) return 0;
        if (hi >= 4 && hi <= 7 && (lo == 1 || lo == 2 || lo == 5 || lo == 4'hB)) return 0;
        return 1;
      end
      1: begin
        if (hi == 4'h6 || hi == 4'hA || hi == 4'hE) return 1;
        if (b >= 8'h1C && b <= 8'h1F) return 1;
        return b inside {8'h08, 8'h09, 8'h30, 8'h35, 8'h38, 8'h3A, 8'h3C, 8'h8C,
                         8'h8F, 8'h9C, 8'hCE, 8'hDE, 8'hDF, 8'hFE, 8'hFF};
      end
      2: return b inside {8'h83, 8'h93, 8'hA3, 8'hB3, 8'hAC, 8'hEE, 8'hEF};
      default: return b inside {8'hA3, 8'hAC, 8'hEE, 8'hEF};
    endcase
  endfunction

  function automatic logic [7:0] pfx_of(input int pg);
    case (pg)
      1: return 8'h18;
      2: return 8'h1A;
      default: return 8'hCD;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One fetch cycle followed by an idle cycle in which outputs are checked.
  task automatic do_op(input logic [7:0] b, input logic [15:0] a, input bit fl,
                       input bit exp_req, input logic [1:0] exp_pg,
                       input logic [15:0] exp_a, input string req);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_byte = b; fetch_addr = a; flush = fl;
    @(negedge clk);
    fetch_valid = 1'b0; flush = 1'b0;
    chk(req, "trap_req", trap_req, exp_req);
    if (exp_req) begin
      chk(req, "trap_addr", trap_addr, exp_a);
      chk(req, "trap_page", trap_page, exp_pg);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; fetch_valid = 1'b0; fetch_byte = 8'h41; fetch_addr = 16'h1234;
    special_mode = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "trap_req in reset", trap_req, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "trap_req", trap_req, 0);
    chk("R1", "trap_addr", trap_addr, 0);
    chk("R1", "trap_page", trap_page, 0);
  endtask

  task automatic t_page1_sweep();
    special_mode = 1'b0;
    for (int op = 0; op < 256; op++) begin
      logic [7:0] b;
      b = 8'(op);
      if (b == 8'h18 || b == 8'h1A || b == 8'hCD) continue;
      do_op(b, 16'h0100 + 16'(op), 0, !ref_legal(0, b, 0), 2'd0, 16'h0100 + 16'(op), "R3");
    end
  endtask

  task automatic t_pages_sweep();
    special_mode = 1'b0;
    for (int pg = 1; pg < 4; pg++) begin
      for (int op = 0; op < 256; op++) begin
        logic [15:0] a;
        string req;
        a = 16'(pg * 16'h1000 + op * 4);
        req = (pg == 1) ? "R4" : (pg == 2) ? "R5" : "R6";
        do_op(pfx_of(pg), a, 0, 0, 2'd0, 16'h0, "R2");
        do_op(8'(op), a + 16'd1, 0, !ref_legal(pg, 8'(op), 0), 2'(pg), a, req);
      end
    end
  endtask

  task automatic t_zero_modes();
    special_mode = 1'b1;
    do_op(8'h00, 16'h5000, 0, 0, 2'd0, 16'h0, "R7");
    do_op(8'h18, 16'h5010, 0, 0, 2'd0, 16'h0, "R7");
    do_op(8'h00, 16'h5011, 0, 1, 2'd1, 16'h5010, "R7");
    special_mode = 1'b0;
    do_op(8'h00, 16'h5020, 0, 1, 2'd0, 16'h5020, "R7");
  endtask

  task automatic t_flush();
    do_op(8'h18, 16'h6000, 0, 0, 2'd0, 16'h0, "R9");
    do_op(8'h61, 16'h6001, 1, 1, 2'd0, 16'h6001, "R9");
    do_op(8'h18, 16'h6010, 0, 0, 2'd0, 16'h0, "R9");
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    do_op(8'h61, 16'h6011, 0, 1, 2'd0, 16'h6011, "R9");
    do_op(8'h18, 16'h6020, 1, 0, 2'd0, 16'h0, "R9");
    do_op(8'h61, 16'h6021, 0, 0, 2'd0, 16'h0, "R9");
  endtask

  task automatic t_hold();
    do_op(8'h41, 16'h7000, 0, 1, 2'd0, 16'h7000, "R10");
    do_op(8'h01, 16'h7001, 0, 0, 2'd0, 16'h0, "R10");
    chk("R10", "trap_addr held", trap_addr, 16'h7000);
    chk("R10", "trap_page held", trap_page, 0);
  endtask

  task automatic t_ignore();
    do_op(8'h1A, 16'h8000, 0, 0, 2'd0, 16'h0, "R11");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      fetch_valid = 1'b0; fetch_byte = 8'h41; fetch_addr = 16'h8005;
      chk("R11", "idle trap_req", trap_req, 0);
    end
    do_op(8'hAC, 16'h8010, 0, 0, 2'd0, 16'h0, "R11");
    do_op(8'h1A, 16'h8020, 0, 0, 2'd0, 16'h0, "R11");
    do_op(8'h41, 16'h8021, 0, 1, 2'd2, 16'h8020, "R11");
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    fetch_valid = 1'b1; fetch_byte = 8'h41; fetch_addr = 16'h9000;
    @(negedge clk);
    fetch_byte = 8'hC7; fetch_addr = 16'h9001;
    chk("R8", "first pulse", trap_req, 1);
    chk("R8", "first addr", trap_addr, 16'h9000);
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R8", "second pulse", trap_req, 1);
    chk("R8", "second addr", trap_addr, 16'h9001);
    @(negedge clk);
    chk("R8", "pulse ends", trap_req, 0);
  endtask

  initial begin
    t_reset();
    t_back_to_back();
    t_hold();
    t_zero_modes();
    t_flush();
    t_ignore();
    t_page1_sweep();
    t_pages_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule